// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects an on-chip requester to an external asynchronous static RAM of 131,072 words by 16 bits. Requests arrive on a valid/ready port with a 17-bit word address, 16-bit write data, a two-bit lane mask and a write flag. The controller turns each request into a properly timed memory cycle on active-low chip-enable, output-enable, write-enable and per-lane strobe pins, plus a shared bidirectional data bus. It returns a one-cycle response, which carries the read data for a read.

The memory has no clock, so every cycle is stretched over a whole number of system clocks. The read window length is taken from the memory's address access time and the clock period. The write pulse length is a separate parameter. A six-state machine sequences the pins:

- `ST_IDLE` accepts a request. It then moves to `ST_RESP` for an empty mask, to `ST_WR_SETUP` for a write, or to `ST_RD_ACCESS` for a read.
- `ST_RD_ACCESS` lasts the read window and then moves to `ST_RESP`.
- `ST_WR_SETUP` lasts one clock and moves to `ST_WR_PULSE`.
- `ST_WR_PULSE` lasts the pulse length and moves to `ST_WR_HOLD`.
- `ST_WR_HOLD` lasts one clock and moves to `ST_RESP`.
- `ST_RESP` lasts one clock and returns to `ST_IDLE`.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, all five memory control pins (`mem_ce_n`, `mem_oe_n`, `mem_we_n`, both bits of `mem_lane_n`) are high, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Mask bit 0 selects the lower lane (data bits 7:0, strobe `mem_lane_n[0]`). Mask bit 1 selects the upper lane (bits 15:8, strobe `mem_lane_n[1]`). While chip enable is low, `mem_lane_n` equals the bitwise inverse of the accepted mask.
- R3: A read holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for exactly READ_WAIT = ceil(T_AA_NS / CLK_PERIOD_NS) + 1 consecutive clocks. The 17-bit address is presented no later than the cycle in which chip enable falls, and stays unchanged while chip enable is low.
- R4: The response to a read comes READ_WAIT + 1 clocks after acceptance. `rsp_rdata` carries the bus value sampled in the last read cycle for requested lanes, and zero for lanes not requested.
- R5: A write runs as follows. One setup clock with chip enable low, write enable high and data driven. Then WR_PULSE_CYC clocks with write enable low and the request data on `mem_dq`. Then one hold clock with write enable high and address and data unchanged. The response comes WR_PULSE_CYC + 3 clocks after acceptance.
- R6: A write changes only the lanes selected by its mask; the other lane keeps its stored value.
- R7: The controller drives `mem_dq` only in the three write states. Its driver is off both in the cycle before output enable falls and in every cycle in which output enable is low.
- R8: A request with mask 0 asserts no chip enable, gets its response one clock after acceptance, and leaves the memory contents unchanged.
- R9: `req_ready` is high only in the idle state. Each accepted request yields exactly one `rsp_valid` pulse, one clock long.
- R10: Output enable and write enable are never low in the same cycle, and write enable is low only while chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unrequested lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Lane strobes, active low, bit 0 lower, bit 1 upper |
| mem_dq | inout | 16 | Shared data bus |

## Verification
A wrong state or counter value shows at the ports within the request it corrupts. A miscounted read window changes how many clocks chip enable stays low, and a window that is too short captures the bus before the memory model has valid data. Either appears in the response of that same read. A lost lane decode leaves a strobe pattern that differs from the mask while chip enable is low, and it corrupts the next read-back of that word. A premature exit from the write states breaks the hold cycle or the pulse count before the response arrives.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RESP
    } lane_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
    parameter int LANES  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata[g*LANE_W +: LANE_W] <= lane_en[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_AA_NS       = 12,
    parameter int WR_PULSE_CYC  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic [DATA_W/8-1:0]       req_mask,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic                      mem_ce_n,
    output logic                      mem_oe_n,
    output logic                      mem_we_n,
    output logic [DATA_W/8-1:0]       mem_lane_n,
    inout  wire  [DATA_W-1:0]         mem_dq
);
    timeunit 1ns;
    timeprecision 1ps;
    import sram_lane_pkg::*;

    localparam int LANES     = DATA_W / 8;
    localparam int READ_WAIT = ceil_div(T_AA_NS, CLK_PERIOD_NS) + 1;
    localparam int MAX_WAIT  = (READ_WAIT > WR_PULSE_CYC) ? READ_WAIT : WR_PULSE_CYC;
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);

    lane_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic              accept;
    logic              tmr_load, tmr_last;
    logic [CNT_W-1:0]  tmr_val;
    logic              drv_en;
    logic              cap_en;

    assign accept = req_valid && req_ready;

    // request registers, loaded only on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_mask == '0)  state_d = ST_RESP;
                    else if (req_write)  state_d = ST_WR_SETUP;
                    else                 state_d = ST_RD_ACCESS;
                end
            end
            ST_RD_ACCESS: if (tmr_last) state_d = ST_RESP;
            ST_WR_SETUP:  state_d = ST_WR_PULSE;
            ST_WR_PULSE:  if (tmr_last) state_d = ST_WR_HOLD;
            ST_WR_HOLD:   state_d = ST_RESP;
            ST_RESP:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // timer loading
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (accept) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(READ_WAIT);
        end else if (state_q == ST_WR_SETUP) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WR_PULSE_CYC);
        end
    end

    // pin outputs from state
    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        mem_ce_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_lane_n = '1;
        drv_en     = 1'b0;
        cap_en     = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RD_ACCESS: begin
                mem_ce_n   = 1'b0;
                mem_oe_n   = 1'b0;
                mem_lane_n = ~mask_q;
                cap_en     = tmr_last;
            end
            ST_WR_SETUP: begin
                mem_ce_n   = 1'b0;
                mem_lane_n = ~mask_q;
                drv_en     = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_ce_n   = 1'b0;
                mem_we_n   = 1'b0;
                mem_lane_n = ~mask_q;
                drv_en     = 1'b1;
            end
            ST_WR_HOLD: begin
                mem_ce_n   = 1'b0;
                mem_lane_n = ~mask_q;
                drv_en     = 1'b1;
            end
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr = addr_q;
    assign mem_dq   = drv_en ? wdata_q : {DATA_W{1'bz}};

    sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_lane_capture #(.LANES(LANES), .DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_en),
        .lane_en (mask_q),
        .bus_in  (mem_dq),
        .rdata   (rsp_rdata)
    );

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && (mem_lane_n == '1))); // R1
    AST_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (mem_lane_n == ~mask_q)); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R3
    AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && drv_en && $stable(mem_addr) && $stable(wdata_q))); // R5
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !drv_en); // R7
    AST_DRIVE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(drv_en)); // R7
    AST_EMPTY_MASK_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_mask == '0)) |=> (mem_ce_n && rsp_valid)); // R8
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R9
    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R10
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n); // R10
endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_NS    = 10;
    localparam int T_AA      = 12;
    localparam int PULSE     = 2;
    localparam int RD_WAIT   = (T_AA + CLK_NS - 1) / CLK_NS + 1;
    localparam int WATCHDOG  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [1:0]  mem_lane_n;
    wire  [15:0] mem_dq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    sram_lane_ctrl #(
        .CLK_PERIOD_NS (CLK_NS),
        .T_AA_NS       (T_AA),
        .WR_PULSE_CYC  (PULSE)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_lane_n (mem_lane_n),
        .mem_dq     (mem_dq)
    );

    // ---------------- behavioural memory model ----------------
    logic [15:0] mm [logic [16:0]];
    realtime     t_change = 0.0;
    logic [1:0]  mdl_en = 2'b00;
    logic [15:0] mdl_word = 16'hEEEE;

    function automatic logic [15:0] mm_read(input logic [16:0] a);
        return mm.exists(a) ? mm[a] : 16'h0000;
    endfunction

    always @(mem_addr or mem_ce_n or mem_oe_n or mem_lane_n) t_change = $realtime;

    initial begin
        #0.5;
        forever begin
            logic rd_cond;
            rd_cond  = !mem_ce_n && !mem_oe_n && mem_we_n;
            mdl_en   = {rd_cond && !mem_lane_n[1], rd_cond && !mem_lane_n[0]};
            mdl_word = (($realtime - t_change) >= T_AA) ? mm_read(mem_addr) : 16'hEEEE;
            #1;
        end
    end

    assign mem_dq[7:0]  = mdl_en[0] ? mdl_word[7:0]  : 8'bz;
    assign mem_dq[15:8] = mdl_en[1] ? mdl_word[15:8] : 8'bz;

    always @(posedge mem_we_n) begin
        if (!mem_ce_n) begin
            logic [15:0] w;
            w = mm_read(mem_addr);
            if (!mem_lane_n[0]) w[7:0]  = mem_dq[7:0];
            if (!mem_lane_n[1]) w[15:8] = mem_dq[15:8];
            mm[mem_addr] = w;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic run_req(input bit wr, input logic [16:0] a, input logic [15:0] d,
                           input logic [1:0] m, output logic [15:0] rd);
        int lat, n_ce, n_we, n_oe;
        bit bad_addr, bad_lane, bad_dat, bad_excl;
        lat = 0; n_ce = 0; n_we = 0; n_oe = 0;
        bad_addr = 0; bad_lane = 0; bad_dat = 0; bad_excl = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 50) begin
            if (!mem_ce_n) begin
                n_ce++;
                if (mem_addr != a) bad_addr = 1;
                if (mem_lane_n != ~m) bad_lane = 1;
            end
            if (!mem_we_n) begin
                n_we++;
                if (mem_dq !== d) bad_dat = 1;
            end
            if (!mem_oe_n) begin
                n_oe++;
                if (!mem_we_n) bad_excl = 1;
            end
            if (req_ready) bad_excl = 1;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        chk(!bad_addr, "R3 address during access", 32'(mem_addr), 32'(a));
        chk(!bad_lane, "R2 lane strobes", 32'(mem_lane_n), 32'(~m));
        chk(!bad_excl, "R10 oe/we exclusive and R9 busy", 32'(bad_excl), 32'd0);
        if (m == 2'b00) begin
            chk(lat == 1, "R8 empty-mask latency", 32'(lat), 32'd1);
            chk(n_ce == 0, "R8 no chip enable", 32'(n_ce), 32'd0);
        end else if (wr) begin
            chk(lat == PULSE + 3, "R5 write latency", 32'(lat), 32'(PULSE + 3));
            chk(n_ce == PULSE + 2, "R5 chip enable length", 32'(n_ce), 32'(PULSE + 2));
            chk(n_we == PULSE, "R5 write pulse length", 32'(n_we), 32'(PULSE));
            chk(!bad_dat, "R5 bus data during pulse", 32'(mem_dq), 32'(d));
        end else begin
            chk(lat == RD_WAIT + 1, "R4 read latency", 32'(lat), 32'(RD_WAIT + 1));
            chk(n_ce == RD_WAIT && n_oe == RD_WAIT, "R3 read window", 32'(n_ce), 32'(RD_WAIT));
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R9 single response pulse", 32'({rsp_valid, req_ready}), 32'b01);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 control pins idle", 32'({mem_ce_n, mem_oe_n, mem_we_n}), 32'b111);
        chk(mem_lane_n == 2'b11, "R1 lane strobes idle", 32'(mem_lane_n), 32'b11);
        chk(req_ready && !rsp_valid, "R1 handshake idle", 32'({req_ready, rsp_valid}), 32'b10);
    endtask

    task automatic t_full_word;
        logic [15:0] r;
        run_req(1'b1, 17'h00000, 16'hA5C3, 2'b11, r);
        run_req(1'b0, 17'h00000, 16'h0000, 2'b11, r);
        chk(r == 16'hA5C3, "R4 full-word read back", 32'(r), 32'hA5C3);
    endtask

    task automatic t_lane_writes;
        logic [15:0] r;
        run_req(1'b1, 17'h00100, 16'h1234, 2'b11, r);
        run_req(1'b1, 17'h00100, 16'h77AB, 2'b01, r);
        run_req(1'b0, 17'h00100, 16'h0000, 2'b11, r);
        chk(r == 16'h12AB, "R6 lower-lane write keeps upper", 32'(r), 32'h12AB);
        run_req(1'b1, 17'h00100, 16'hCD55, 2'b10, r);
        run_req(1'b0, 17'h00100, 16'h0000, 2'b11, r);
        chk(r == 16'hCDAB, "R6 upper-lane write keeps lower", 32'(r), 32'hCDAB);
    endtask

    task automatic t_partial_read;
        logic [15:0] r;
        run_req(1'b0, 17'h00100, 16'h0000, 2'b01, r);
        chk(r == 16'h00AB, "R4 lower-lane read zeroes upper", 32'(r), 32'h00AB);
        run_req(1'b0, 17'h00100, 16'h0000, 2'b10, r);
        chk(r == 16'hCD00, "R4 upper-lane read zeroes lower", 32'(r), 32'hCD00);
    endtask

    task automatic t_empty_mask;
        logic [15:0] r;
        run_req(1'b1, 17'h00100, 16'hFFFF, 2'b00, r);
        run_req(1'b0, 17'h00100, 16'h0000, 2'b00, r);
        run_req(1'b0, 17'h00100, 16'h0000, 2'b11, r);
        chk(r == 16'hCDAB, "R8 empty-mask write left word intact", 32'(r), 32'hCDAB);
    endtask

    task automatic t_address_edges;
        logic [15:0] r;
        run_req(1'b1, 17'h1FFFF, 16'h8001, 2'b11, r);
        run_req(1'b0, 17'h1FFFF, 16'h0000, 2'b11, r);
        chk(r == 16'h8001, "R3 top address read back", 32'(r), 32'h8001);
        run_req(1'b0, 17'h00000, 16'h0000, 2'b11, r);
        chk(r == 16'hA5C3, "R3 bottom address untouched", 32'(r), 32'hA5C3);
    endtask

    // R7: reads issued right after writes must return model data with no bus fight
    task automatic t_turnaround;
        logic [15:0] r;
        for (int i = 0; i < 4; i++) begin
            logic [16:0] a;
            logic [15:0] d;
            a = 17'h02000 + 17'(i * 3);
            d = 16'h3C00 + 16'(i * 16'h0111);
            run_req(1'b1, a, d, 2'b11, r);
            run_req(1'b0, a, 16'h0000, 2'b11, r);
            chk(r == d, "R7 read after write turnaround", 32'(r), 32'(d));
        end
    endtask

    initial begin
        #(CLK_NS * WATCHDOG);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_word();
        t_lane_writes();
        t_partial_read();
        t_empty_mask();
        t_address_edges();
        t_turnaround();
        repeat (2) @(negedge clk);
        report();
    end
endmodule